// File: doc/BRIEF.md
# Three-Channel Edge Capture Unit

The block watches three external input pins. When a pin shows the edge its channel is set to look for, the block copies a shared 16-bit free-running count into that channel's capture register. Each channel has three controls: an enable, a 2-bit edge select and a noise-filter enable. Every pin passes through a two-flop synchronizer before any edge detection. The filter, when enabled, adds a fixed latency of four samples and rejects short glitches.

A capture sets a sticky per-channel flag. Only a software clear strobe resets the flag. The three flags are ORed together and gated by one interrupt enable to form a single registered interrupt request. Each channel also exports a one-cycle capture strobe, which a neighbouring timer can use to reset its count.

The count source, the prescaler and register decoding sit outside the block.

Top module: `icap_unit`

## Requirements
- R1: After reset, all capture registers, flags, capture strobes and `irq_o` are zero.
- R2: Edge select 00 captures on a rising pin edge. With the filter off, `cap_strobe_o[i]` is high in the third cycle after the pin changes (the pin is sampled at three rising clock edges). In that same cycle `cap_val_o[i*16 +: 16]` holds the `cnt_i` value present in the cycle before.
- R3: Edge select 01 captures on a falling pin edge only.
- R4: Edge select 10 captures on both rising and falling pin edges.
- R5: Edge select 11 never captures. The capture register and the flag stay unchanged.
- R6: While `ch_en_i[i]` is 0, edges on pin i cause no strobe, no flag and no change to the capture register.
- R7: A capture on one channel leaves the strobes, flags and capture registers of the other channels unchanged.
- R8: A capture sets `flag_o[i]`. The flag stays set until `flag_clr_i[i]` is high for a cycle, and it reads 0 in the following cycle.
- R9: If a capture and a clear of the same flag fall in the same cycle, the flag stays set.
- R10: `irq_o` is the OR of the three flags ANDed with `irq_en_i`, registered one cycle behind both of them.
- R11: With the filter enabled, a level change is accepted only after four consecutive equal samples. This adds exactly four cycles of latency, so the strobe comes in the seventh cycle after the pin change. A pulse held for three cycles produces no capture; a pulse held for four cycles is accepted.
- R12: Each capture produces a `cap_strobe_o[i]` pulse exactly one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | 16 | Shared free-running count to snapshot |
| pin_i | input | 3 | Asynchronous capture input pins |
| ch_en_i | input | 3 | Per-channel capture enable |
| trig_sel_i | input | 6 | Per-channel edge select, channel i in bits [2i+1:2i] |
| filt_en_i | input | 3 | Per-channel noise filter enable |
| flag_clr_i | input | 3 | Per-channel flag clear strobe |
| irq_en_i | input | 1 | Shared capture interrupt enable |
| cap_val_o | output | 48 | Capture registers, channel i in bits [16i+15:16i] |
| flag_o | output | 3 | Sticky capture flags |
| cap_strobe_o | output | 3 | One-cycle capture strobes |
| irq_o | output | 1 | Combined capture interrupt request |

## Verification
The bench sweeps every channel through all four edge selects, both enable values and both filter settings. For each combination it drives a rising and then a falling edge and checks the strobe cycle by cycle. A wrong select decode or a wrong edge polarity would show as a capture on the wrong transition. A missing enable gate, or crosstalk between channels, would show as a strobe or a register change where none is expected.

The bench also lines up a software clear with a capture in the same cycle. A design that gave priority to the clear would drop the flag there. The filter is driven with pulses of three and four cycles; an off-by-one counter would accept the short pulse or reject the long one. Finally the bench toggles the interrupt enable to catch an ungated or unregistered request.

// File: rtl/icap_pkg.sv
package icap_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CNTW = (LEN > 1) ? $clog2(LEN) : 1;

  logic            level;
  logic [CNTW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b0;
      run   <= '0;
    end else if (din == level) begin
      run <= '0;
    end else if (run == CNTW'(LEN - 1)) begin
      level <= din;
      run   <= '0;
    end else begin
      run <= run + 1'b1;
    end
  end

  assign dout = level;
endmodule

// File: rtl/icap_channel.sv
module icap_channel
  import icap_pkg::*;
#(
  parameter int CW       = 16,
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic          pin,
  input  logic          en,
  input  edge_sel_e     sel,
  input  logic          filt_en,
  input  logic          clr,
  output logic [CW-1:0] cap,
  output logic          flag,
  output logic          strobe
);
  logic synced, filtered, lvl, prev, rise, fall, qual, hit;

  icap_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst(rst), .din(pin), .dout(synced)
  );

  icap_filter #(.LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst(rst), .din(synced), .dout(filtered)
  );

  assign lvl  = filt_en ? filtered : synced;
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

  always_comb begin
    unique case (sel)
      EDGE_RISE: qual = rise;
      EDGE_FALL: qual = fall;
      EDGE_BOTH: qual = rise | fall;
      default:   qual = 1'b0;
    endcase
  end

  assign hit = en & qual;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev   <= 1'b0;
      cap    <= '0;
      flag   <= 1'b0;
      strobe <= 1'b0;
    end else begin
      prev   <= lvl;
      strobe <= hit;
      if (hit) cap <= cnt;
      if (hit)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/icap_unit.sv
module icap_unit
  import icap_pkg::*;
#(
  parameter int NCH      = 3,
  parameter int CW       = 16,
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW-1:0]     cnt_i,
  input  logic [NCH-1:0]    pin_i,
  input  logic [NCH-1:0]    ch_en_i,
  input  logic [2*NCH-1:0]  trig_sel_i,
  input  logic [NCH-1:0]    filt_en_i,
  input  logic [NCH-1:0]    flag_clr_i,
  input  logic              irq_en_i,
  output logic [NCH*CW-1:0] cap_val_o,
  output logic [NCH-1:0]    flag_o,
  output logic [NCH-1:0]    cap_strobe_o,
  output logic              irq_o
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    icap_channel #(.CW(CW), .SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .cnt    (cnt_i),
      .pin    (pin_i[i]),
      .en     (ch_en_i[i]),
      .sel    (edge_sel_e'(trig_sel_i[2*i +: 2])),
      .filt_en(filt_en_i[i]),
      .clr    (flag_clr_i[i]),
      .cap    (cap_val_o[i*CW +: CW]),
      .flag   (flag_o[i]),
      .strobe (cap_strobe_o[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= irq_en_i & (|flag_o);
  end
endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk #(
  parameter int NCH = 3,
  parameter int CW  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [NCH-1:0]    ch_en_i,
  input logic [2*NCH-1:0]  trig_sel_i,
  input logic [NCH-1:0]    flag_clr_i,
  input logic              irq_en_i,
  input logic [NCH*CW-1:0] cap_val_o,
  input logic [NCH-1:0]    flag_o,
  input logic [NCH-1:0]    cap_strobe_o,
  input logic              irq_o
);
  for (genvar i = 0; i < NCH; i++) begin : g_c
    // R8
    strobe_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
      cap_strobe_o[i] |-> flag_o[i]);
    // R8
    flag_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(flag_o[i]) |-> cap_strobe_o[i]);
    // R8
    flag_fall_src_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(flag_o[i]) |-> $past(flag_clr_i[i]));
    // R7
    cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !cap_strobe_o[i] |-> $stable(cap_val_o[i*CW +: CW]));
    // R6
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !ch_en_i[i] |=> !cap_strobe_o[i]);
    // R5
    sel_none_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (trig_sel_i[2*i +: 2] == 2'b11) |=> !cap_strobe_o[i]);
  end
  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_en_i |=> !irq_o);
  // R10
  irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_o == '0) |=> !irq_o);
endmodule

bind icap_unit icap_unit_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .ch_en_i(ch_en_i), .trig_sel_i(trig_sel_i),
  .flag_clr_i(flag_clr_i), .irq_en_i(irq_en_i), .cap_val_o(cap_val_o),
  .flag_o(flag_o), .cap_strobe_o(cap_strobe_o), .irq_o(irq_o)
);

// File: tb/sim_icap_unit.sv
module sim_icap_unit;
  localparam int NCH = 3;
  localparam int CW  = 16;

  logic              clk = 1'b0;
  logic              rst;
  logic [CW-1:0]     cnt_i;
  logic [NCH-1:0]    pin_i;
  logic [NCH-1:0]    ch_en_i;
  logic [2*NCH-1:0]  trig_sel_i;
  logic [NCH-1:0]    filt_en_i;
  logic [NCH-1:0]    flag_clr_i;
  logic              irq_en_i;
  logic [NCH*CW-1:0] cap_val_o;
  logic [NCH-1:0]    flag_o;
  logic [NCH-1:0]    cap_strobe_o;
  logic              irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [CW-1:0]  exp_cap [NCH];
  logic [NCH-1:0] exp_flag;

  always #5 clk = ~clk;

  icap_unit u0 (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_state(string req);
    for (int c = 0; c < NCH; c++)
      check(req, 64'(cap_val_o[c*CW +: CW]), 64'(exp_cap[c]));
    check(req, 64'(flag_o), 64'(exp_flag));
  endtask

  // drive pin ch to lvl now, watch strobes for lat+3 cycles
  task automatic edge_run(int ch, bit lvl, bit expect_hit, int lat, logic [CW-1:0] cv, string req);
    cnt_i = cv;
    pin_i[ch] = lvl;
    for (int t = 1; t <= lat + 3; t++) begin
      step(1);
      check(req, 64'(cap_strobe_o[ch]), 64'((t == lat) && expect_hit));
      for (int o = 0; o < NCH; o++)
        if (o != ch) check("R7", 64'(cap_strobe_o[o]), 64'd0);
    end
    if (expect_hit) begin
      exp_cap[ch] = cv;
      exp_flag[ch] = 1'b1;
    end
    check_state(req);
    check("R10", 64'(irq_o), 64'(irq_en_i & (|exp_flag)));
  endtask

  task automatic clear_all();
    flag_clr_i = '1;
    step(1);
    flag_clr_i = '0;
    exp_flag = '0;
    step(1);
    check("R8", 64'(flag_o), 64'd0);
  endtask

  initial begin
    rst = 1'b1; cnt_i = '0; pin_i = '0; ch_en_i = '0; trig_sel_i = '0;
    filt_en_i = '0; flag_clr_i = '0; irq_en_i = 1'b0;
    for (int c = 0; c < NCH; c++) exp_cap[c] = '0;
    exp_flag = '0;
    step(3);
    rst = 1'b0;
    step(1);
    check_state("R1");
    check("R1", 64'(cap_strobe_o), 64'd0);
    check("R1", 64'(irq_o), 64'd0);

    irq_en_i = 1'b1;
    // sweep: channel x select x enable x filter
    for (int ch = 0; ch < NCH; ch++)
      for (int sel = 0; sel < 4; sel++)
        for (int en = 0; en < 2; en++)
          for (int f = 0; f < 2; f++) begin
            string rq;
            bit hr, hf;
            int lat;
            logic [CW-1:0] base;
            rq = (en == 0) ? "R6" : (sel == 0) ? "R2" : (sel == 1) ? "R3" :
                 (sel == 2) ? "R4" : "R5";
            if (f == 1) rq = {rq, "/R11"};
            hr = (en == 1) && (sel == 0 || sel == 2);
            hf = (en == 1) && (sel == 1 || sel == 2);
            lat = (f == 1) ? 7 : 3;
            base = CW'(ch * 16'h1000 + sel * 16'h100 + en * 16'h20 + f * 16'h4);
            clear_all();
            ch_en_i[ch] = 1'(en);
            trig_sel_i[2*ch +: 2] = 2'(sel);
            filt_en_i[ch] = 1'(f);
            step(1);
            edge_run(ch, 1'b1, hr, lat, base + 16'h1, rq);
            edge_run(ch, 1'b0, hf, lat, base + 16'h2, rq);
            ch_en_i[ch] = 1'b0;
          end

    // R12 and R8: sticky flag across idle cycles
    ch_en_i[1] = 1'b1; trig_sel_i[3:2] = 2'b10; filt_en_i[1] = 1'b0;
    clear_all();
    edge_run(1, 1'b1, 1'b1, 3, 16'hBEEF, "R12");
    step(20);
    check("R8", 64'(flag_o[1]), 64'd1);

    // R9: capture and clear in the same cycle
    cnt_i = 16'hCAFE;
    pin_i[1] = 1'b0;
    step(2);
    flag_clr_i[1] = 1'b1;
    step(1);
    flag_clr_i[1] = 1'b0;
    check("R9", 64'(cap_strobe_o[1]), 64'd1);
    check("R9", 64'(flag_o[1]), 64'd1);
    check("R9", 64'(cap_val_o[CW +: CW]), 64'hCAFE);
    exp_cap[1] = 16'hCAFE;
    flag_clr_i[1] = 1'b1;
    step(1);
    flag_clr_i[1] = 1'b0;
    check("R8", 64'(flag_o[1]), 64'd0);

    // R10: enable gating and one-cycle lag
    irq_en_i = 1'b0;
    edge_run(1, 1'b1, 1'b1, 3, 16'h1234, "R10");
    step(3);
    check("R10", 64'(irq_o), 64'd0);
    irq_en_i = 1'b1;
    step(1);
    check("R10", 64'(irq_o), 64'd1);
    flag_clr_i = '1;
    step(1);
    flag_clr_i = '0;
    check("R10", 64'(irq_o), 64'd1);
    step(1);
    check("R10", 64'(irq_o), 64'd0);
    exp_flag = '0;
    pin_i[1] = 1'b0;
    step(6);
    flag_clr_i = '1; step(1); flag_clr_i = '0; step(1);

    // R11: short pulse rejected, four-cycle pulse accepted
    ch_en_i[2] = 1'b1; trig_sel_i[5:4] = 2'b10; filt_en_i[2] = 1'b1;
    cnt_i = 16'h5555;
    pin_i[2] = 1'b1;
    step(3);
    pin_i[2] = 1'b0;
    for (int t = 0; t < 12; t++) begin
      check("R11", 64'(cap_strobe_o[2]), 64'd0);
      step(1);
    end
    check("R11", 64'(flag_o[2]), 64'd0);
    cnt_i = 16'h6666;
    pin_i[2] = 1'b1;
    step(4);
    pin_i[2] = 1'b0;
    step(3);
    check("R11", 64'(cap_strobe_o[2]), 64'd1);
    check("R11", 64'(cap_val_o[2*CW +: CW]), 64'h6666);
    step(1);
    check("R12", 64'(cap_strobe_o[2]), 64'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule